// File: doc/BRIEF.md
# Boundary Scan Instruction Register and Decoder

This block holds the instruction register of a boundary-scan test port and turns the active instruction into the mode controls that the rest of the test logic needs. An external test-access state machine supplies capture, shift and update strobes, a path select, and a reset. While the instruction path is selected, a new code is shifted in least significant bit first. The update strobe then copies it into the active instruction. The block also contains the one-bit bypass register and the serial output multiplexer for the data path.

From the active instruction the block decodes four controls. The first picks the serial path: the boundary chain or the bypass bit. The second hands the pins to the chain's latched values. The third forces every pin output to high impedance. The fourth enables internal-test mode. Holding instructions keep the pins steady while only the single bypass bit sits in the serial path.

Top module: `bscan_ir_top`

## Requirements
- R1: While `rstN` is low, and after it is released, the active instruction is the bypass code 1111 and all four mode controls are 0.
- R2: On a capture strobe with `irSelect` high, the shift stage loads 0001, so the first four shifted-out bits are 1, 0, 0, 0.
- R3: Each shift strobe with `irSelect` high moves the shift stage one place toward bit 0 and enters `serialIn` at bit 3, so four shifts load a code least significant bit first; `serialOut` shows bit 0 of the stage while `irSelect` is high.
- R4: The active instruction and its decoded controls change only on an update strobe with `irSelect` high; they hold while a new code is being captured or shifted.
- R5: Code 1111 (bypass) selects the bypass bit and clears every other control.
- R6: Code 0010 (sample/preload) selects the boundary chain and leaves the pins under core control: `chainSelect`=1, `pinsFromChain`=0, `outputsHighZ`=0, `internalTest`=0.
- R7: Code 0000 (external test) selects the boundary chain and drives the pins from it: `chainSelect`=1, `pinsFromChain`=1.
- R8: Code 0011 (internal test) selects the boundary chain and sets `internalTest`=1, with `pinsFromChain`=0.
- R9: Code 0100 (clamp) sets `pinsFromChain`=1 while `chainSelect`=0, so the bypass bit is the serial path.
- R10: Code 0101 (high impedance) sets `outputsHighZ`=1 with `chainSelect`=0 and `pinsFromChain`=0.
- R11: Every other code decodes exactly as bypass.
- R12: On a capture strobe with `irSelect` low, the bypass bit loads 0. When the bypass bit is the selected path, `serialOut` gives `serialIn` delayed by one shift.
- R13: With `irSelect` low and the boundary chain selected, `serialOut` follows `chainIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irSelect | input | 1 | 1: strobes act on the instruction path; 0: on the data path |
| captureEn | input | 1 | Capture strobe |
| shiftEn | input | 1 | Shift strobe, one bit per clock |
| updateEn | input | 1 | Update strobe |
| serialIn | input | 1 | Serial test data in |
| chainIn | input | 1 | Serial output of the external boundary chain |
| serialOut | output | 1 | Serial test data out |
| activeInstr | output | 4 | Active instruction code |
| chainSelect | output | 1 | Boundary chain is the data path |
| pinsFromChain | output | 1 | Pin outputs driven from the chain's latched values |
| outputsHighZ | output | 1 | All pin outputs forced to high impedance |
| internalTest | output | 1 | Internal-test mode active |

## Verification
The assertions assume that the controlling state machine raises at most one of capture, shift and update in any clock. They also assume that `irSelect` does not change in the cycle that follows a capture strobe. The bench keeps to this by driving every strobe from a single sequencing task: capture, then shift, then update, each strobe alone in its cycle. It changes `irSelect` only between complete sequences.

// File: rtl/bscan_ir_pkg.sv
package bscan_ir_pkg;
  localparam int IR_LEN = 4;
  typedef logic [IR_LEN-1:0] irCode_t;

  localparam irCode_t CODE_EXTEST  = 4'b0000;
  localparam irCode_t CODE_SAMPLE  = 4'b0010;
  localparam irCode_t CODE_INTEST  = 4'b0011;
  localparam irCode_t CODE_CLAMP   = 4'b0100;
  localparam irCode_t CODE_HIGHZ   = 4'b0101;
  localparam irCode_t CODE_BYPASS  = {IR_LEN{1'b1}};
  // low two bits fixed at 01, upper bits zero
  localparam irCode_t CAPTURE_PATTERN = irCode_t'(2'b01);

  typedef struct packed {
    logic irCapture;
    logic irShift;
    logic irUpdate;
    logic bypCapture;
    logic bypShift;
  } strobes_t;

  typedef struct packed {
    logic chainSelect;
    logic pinsFromChain;
    logic outputsHighZ;
    logic internalTest;
  } modeCtl_t;
endpackage

// File: rtl/bscan_ir_ctrl.sv
module bscan_ir_ctrl
  import bscan_ir_pkg::*;
(
  input  logic     irSelect,
  input  logic     captureEn,
  input  logic     shiftEn,
  input  logic     updateEn,
  output strobes_t strobes
);
  // Route each strobe to the instruction path or to the bypass bit.
  always_comb begin
    strobes.irCapture  = irSelect  & captureEn;
    strobes.irShift    = irSelect  & shiftEn & ~captureEn;
    strobes.irUpdate   = irSelect  & updateEn & ~captureEn & ~shiftEn;
    strobes.bypCapture = ~irSelect & captureEn;
    strobes.bypShift   = ~irSelect & shiftEn & ~captureEn;
  end
endmodule

// File: rtl/bscan_ir_decode.sv
module bscan_ir_decode
  import bscan_ir_pkg::*;
(
  input  irCode_t  code,
  output modeCtl_t mode
);
  always_comb begin
    mode = '0;
    unique case (code)
      CODE_EXTEST: begin mode.chainSelect = 1'b1; mode.pinsFromChain = 1'b1; end
      CODE_SAMPLE: begin mode.chainSelect = 1'b1; end
      CODE_INTEST: begin mode.chainSelect = 1'b1; mode.internalTest = 1'b1; end
      CODE_CLAMP:  begin mode.pinsFromChain = 1'b1; end
      CODE_HIGHZ:  begin mode.outputsHighZ = 1'b1; end
      default:     begin mode = '0; end // bypass and every unassigned code
    endcase
  end
endmodule

// File: rtl/bscan_ir_datapath.sv
module bscan_ir_datapath
  import bscan_ir_pkg::*;
(
  input  logic     tck,
  input  logic     rstN,
  input  strobes_t strobes,
  input  logic     irSelect,
  input  logic     chainSelect,
  input  logic     serialIn,
  input  logic     chainIn,
  output irCode_t  activeInstr,
  output logic     serialOut
);
  irCode_t irStage;
  irCode_t irActive;
  logic    bypassBit;

  // Shift stage: one cell per bit, the top cell takes the serial input.
  for (genvar i = 0; i < IR_LEN; i++) begin : g_cell
    logic nextBit;
    if (i == IR_LEN - 1) begin : g_top
      assign nextBit = serialIn;
    end else begin : g_mid
      assign nextBit = irStage[i+1];
    end
    always_ff @(posedge tck or negedge rstN) begin
      if (!rstN)                 irStage[i] <= 1'b0;
      else if (strobes.irCapture) irStage[i] <= CAPTURE_PATTERN[i];
      else if (strobes.irShift)   irStage[i] <= nextBit;
    end
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                 irActive <= CODE_BYPASS;
    else if (strobes.irUpdate) irActive <= irStage;
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                   bypassBit <= 1'b0;
    else if (strobes.bypCapture) bypassBit <= 1'b0;
    else if (strobes.bypShift)   bypassBit <= serialIn;
  end

  assign activeInstr = irActive;

  always_comb begin
    if (irSelect)         serialOut = irStage[0];
    else if (chainSelect) serialOut = chainIn;
    else                  serialOut = bypassBit;
  end
endmodule

// File: rtl/bscan_ir_top.sv
module bscan_ir_top
  import bscan_ir_pkg::*;
(
  input  logic              tck,
  input  logic              rstN,
  input  logic              irSelect,
  input  logic              captureEn,
  input  logic              shiftEn,
  input  logic              updateEn,
  input  logic              serialIn,
  input  logic              chainIn,
  output logic              serialOut,
  output logic [IR_LEN-1:0] activeInstr,
  output logic              chainSelect,
  output logic              pinsFromChain,
  output logic              outputsHighZ,
  output logic              internalTest
);
  strobes_t strobes;
  modeCtl_t mode;
  irCode_t  instr;

  bscan_ir_ctrl ctrl_i (
    .irSelect (irSelect),
    .captureEn(captureEn),
    .shiftEn  (shiftEn),
    .updateEn (updateEn),
    .strobes  (strobes)
  );

  bscan_ir_datapath dp_i (
    .tck        (tck),
    .rstN       (rstN),
    .strobes    (strobes),
    .irSelect   (irSelect),
    .chainSelect(mode.chainSelect),
    .serialIn   (serialIn),
    .chainIn    (chainIn),
    .activeInstr(instr),
    .serialOut  (serialOut)
  );

  bscan_ir_decode dec_i (
    .code(instr),
    .mode(mode)
  );

  assign activeInstr   = instr;
  assign chainSelect   = mode.chainSelect;
  assign pinsFromChain = mode.pinsFromChain;
  assign outputsHighZ  = mode.outputsHighZ;
  assign internalTest  = mode.internalTest;
endmodule

// File: rtl/bscan_ir_checker.sv
module bscan_ir_checker
  import bscan_ir_pkg::*;
(
  input logic              tck,
  input logic              rstN,
  input logic              irSelect,
  input logic              captureEn,
  input logic              updateEn,
  input logic              serialOut,
  input logic [IR_LEN-1:0] activeInstr,
  input logic              chainSelect,
  input logic              pinsFromChain,
  input logic              outputsHighZ,
  input logic              internalTest
);
  assert_reset_bypass_R1: assert property (@(posedge tck) disable iff (!rstN)
    $rose(rstN) |-> (activeInstr == CODE_BYPASS) && !chainSelect && !pinsFromChain);

  assert_ir_capture_R2: assert property (@(posedge tck) disable iff (!rstN)
    (irSelect && captureEn) |=> (!irSelect || serialOut));

  assert_hold_no_update_R4: assert property (@(posedge tck) disable iff (!rstN)
    !(irSelect && updateEn) |=> $stable(activeInstr) && $stable(chainSelect)
                                && $stable(pinsFromChain) && $stable(outputsHighZ));

  assert_extest_R7: assert property (@(posedge tck) disable iff (!rstN)
    (activeInstr == CODE_EXTEST) |-> chainSelect && pinsFromChain);

  assert_clamp_R9: assert property (@(posedge tck) disable iff (!rstN)
    (activeInstr == CODE_CLAMP) |-> !chainSelect && pinsFromChain);

  assert_highz_R10: assert property (@(posedge tck) disable iff (!rstN)
    outputsHighZ |-> !chainSelect && !pinsFromChain && !internalTest);

  assert_modes_exclusive_R11: assert property (@(posedge tck) disable iff (!rstN)
    $onehot0({outputsHighZ, pinsFromChain, internalTest}));

  assert_bypass_capture_R12: assert property (@(posedge tck) disable iff (!rstN)
    (!irSelect && captureEn) |=> ((irSelect || chainSelect) || !serialOut));
endmodule

bind bscan_ir_top bscan_ir_checker chk_i (
  .tck          (tck),
  .rstN         (rstN),
  .irSelect     (irSelect),
  .captureEn    (captureEn),
  .updateEn     (updateEn),
  .serialOut    (serialOut),
  .activeInstr  (activeInstr),
  .chainSelect  (chainSelect),
  .pinsFromChain(pinsFromChain),
  .outputsHighZ (outputsHighZ),
  .internalTest (internalTest)
);

// File: tb/bscan_ir_top_tb_top.sv
`timescale 1ns/1ps
module bscan_ir_top_tb_top;
  import bscan_ir_pkg::*;

  logic tck = 1'b0;
  logic rstN = 1'b0;
  logic irSelect = 1'b0, captureEn = 1'b0, shiftEn = 1'b0, updateEn = 1'b0;
  logic serialIn = 1'b0, chainIn = 1'b0;
  logic serialOut, chainSelect, pinsFromChain, outputsHighZ, internalTest;
  logic [IR_LEN-1:0] activeInstr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  irCode_t curCode = CODE_BYPASS;

  always #2.5 tck = ~tck;

  bscan_ir_top dut_i (
    .tck(tck), .rstN(rstN), .irSelect(irSelect), .captureEn(captureEn),
    .shiftEn(shiftEn), .updateEn(updateEn), .serialIn(serialIn), .chainIn(chainIn),
    .serialOut(serialOut), .activeInstr(activeInstr), .chainSelect(chainSelect),
    .pinsFromChain(pinsFromChain), .outputsHighZ(outputsHighZ), .internalTest(internalTest)
  );

  // {code, expected {chainSelect, pinsFromChain, outputsHighZ, internalTest}}
  localparam logic [7:0] VECS [8] = '{
    {4'b0000, 4'b1100}, {4'b0010, 4'b1000}, {4'b0011, 4'b1001}, {4'b0100, 4'b0100},
    {4'b0101, 4'b0010}, {4'b1111, 4'b0000}, {4'b1010, 4'b0000}, {4'b0111, 4'b0000}
  };

  function automatic string reqOf(irCode_t c);
    case (c)
      4'b0000: return "R7";
      4'b0010: return "R6";
      4'b0011: return "R8";
      4'b0100: return "R9";
      4'b0101: return "R10";
      4'b1111: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck);
    #1;
  endtask

  function automatic logic [3:0] modeNow();
    return {chainSelect, pinsFromChain, outputsHighZ, internalTest};
  endfunction

  // Capture, shift four bits LSB first, update; checks R2, R3 and R4 on the way.
  task automatic loadInstr(input irCode_t code);
    irSelect = 1'b1; captureEn = 1'b1;
    tick();
    captureEn = 1'b0; shiftEn = 1'b1;
    for (int i = 0; i < IR_LEN; i++) begin
      serialIn = code[i];
      #0.5;
      check(serialOut == CAPTURE_PATTERN[i], "R2 capture bit", 8'(serialOut), 8'(CAPTURE_PATTERN[i]));
      check(activeInstr == curCode, "R4 hold during shift", 8'(activeInstr), 8'(curCode));
      tick();
    end
    shiftEn = 1'b0;
    #0.5;
    check(serialOut == code[0], "R3 shifted stage bit0", 8'(serialOut), 8'(code[0]));
    check(activeInstr == curCode, "R4 hold before update", 8'(activeInstr), 8'(curCode));
    updateEn = 1'b1;
    tick();
    updateEn = 1'b0; irSelect = 1'b0;
    curCode = code;
    check(activeInstr == code, "R3 loaded code", 8'(activeInstr), 8'(code));
  endtask

  task automatic bypassRun(input string req);
    logic [3:0] pat = 4'b1011;
    logic expBit = 1'b0;
    irSelect = 1'b0; captureEn = 1'b1;
    tick();
    captureEn = 1'b0; shiftEn = 1'b1;
    for (int i = 0; i < 4; i++) begin
      serialIn = pat[i];
      chainIn = ~expBit;
      #0.5;
      check(serialOut == expBit, req, 8'(serialOut), 8'(expBit));
      expBit = pat[i];
      tick();
    end
    shiftEn = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check(activeInstr == CODE_BYPASS, "R1 in reset", 8'(activeInstr), 8'(CODE_BYPASS));
    check(modeNow() == 4'b0000, "R1 controls in reset", 8'(modeNow()), 8'h00);
    rstN = 1'b1;
    tick();
    check(activeInstr == CODE_BYPASS, "R1 after release", 8'(activeInstr), 8'(CODE_BYPASS));

    for (int v = 0; v < 8; v++) begin
      loadInstr(irCode_t'(VECS[v][7:4]));
      check(modeNow() == VECS[v][3:0], reqOf(irCode_t'(VECS[v][7:4])), 8'(modeNow()), 8'(VECS[v][3:0]));
    end

    // R12 bypass bit under bypass and clamp
    loadInstr(CODE_BYPASS);
    bypassRun("R12 bypass delay");
    loadInstr(CODE_CLAMP);
    check(pinsFromChain && !chainSelect, "R9 clamp holds pins", 8'(modeNow()), 8'b0100);
    bypassRun("R9 clamp uses bypass bit");

    // R13 chain passes through under sample/preload
    loadInstr(CODE_SAMPLE);
    irSelect = 1'b0; chainIn = 1'b1; #0.5;
    check(serialOut == 1'b1, "R13 chain high", 8'(serialOut), 8'd1);
    chainIn = 1'b0; #0.5;
    check(serialOut == 1'b0, "R13 chain low", 8'(serialOut), 8'd0);

    // R4: capture and shift without update leave the active code alone
    irSelect = 1'b1; captureEn = 1'b1; tick();
    captureEn = 1'b0; shiftEn = 1'b1; serialIn = 1'b1;
    repeat (4) tick();
    shiftEn = 1'b0; irSelect = 1'b0; tick();
    check(activeInstr == CODE_SAMPLE, "R4 no update", 8'(activeInstr), 8'(CODE_SAMPLE));

    // R1: reset in the middle of external test
    loadInstr(CODE_EXTEST);
    rstN = 1'b0; #1;
    check(activeInstr == CODE_BYPASS, "R1 async reset", 8'(activeInstr), 8'(CODE_BYPASS));
    check(modeNow() == 4'b0000, "R1 controls cleared", 8'(modeNow()), 8'h00);
    tick();
    rstN = 1'b1; curCode = CODE_BYPASS;
    tick();

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule